// File: doc/BRIEF.md
# Back-Current Fault Retry Cycler

This block guards a regulator output against a reverse current pushed into it from outside, for example when a higher line voltage is tied onto an output that has been set lower. A comparator outside the block raises `rev_flag` while the reverse current is above its threshold. The block acts only when that indication has lasted longer than a qualification time. It then switches the regulator output off for a fixed blanking interval and raises a fault status bit for exactly that interval. After the interval it re-enables the output and watches the flag again from scratch. If the reverse source is still present, the output settles into a steady short-on / long-off retry rhythm. Once the source is gone, the output stays on.

All time is counted in pulses of `ms_tick`, a one-cycle strobe issued once per millisecond. The qualification length `QUAL_MS` (default 2) and the blanking length `OFF_MS` (default 50) are parameters. Both inputs are synchronous to `clk`.

The controller has three states. In `ST_ARMED` the output is on and the flag is low. In `ST_QUALIFY` the output is on while the flag has been high since the previous cycle. In `ST_BLANK` the output is off and the fault bit is set. The transitions are:
- *flag seen* takes ARMED to QUALIFY.
- *flag dropped* takes QUALIFY back to ARMED and clears the count.
- *fault qualified* takes QUALIFY to BLANK.
- *blank expired* takes BLANK to ARMED.

Top module: `backcur_retry`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_en` is 1 and `bc_fault` is 0.
- R2: If `rev_flag` goes low before qualification completes, the output stays enabled and the tick count restarts from zero. The next high period must then collect its full count again.
- R3: Tick counting starts in the cycle after `rev_flag` is first seen high. On the (QUAL_MS+1)-th tick counted while the flag stays high, the output is disabled from the next cycle on.
- R4: The output stays disabled for exactly OFF_MS ticks. It is re-enabled in the cycle after the OFF_MS-th tick of the blanking interval.
- R5: `bc_fault` is 1 exactly in the cycles where `out_en` is 0. The fault bit is never set while the output is enabled.
- R6: Changes of `rev_flag` during the blanking interval neither shorten nor extend it.
- R7: While `rev_flag` stays high, the block repeats the cycle indefinitely: a fresh qualification, then a full blanking interval, again and again.
- R8: If `rev_flag` is low when the blanking interval ends, the output remains enabled as long as the flag stays low.
- R9: The output can only be disabled or re-enabled in the cycle after an `ms_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse, once per millisecond |
| rev_flag | input | 1 | Reverse current above threshold (synchronous) |
| out_en | output | 1 | 1 = regulator output enabled |
| bc_fault | output | 1 | 1 = back-current fault, output blanked |

## Verification
The embedded assertions check the following on every cycle:
- State changes into and out of blanking happen only right after a tick.
- Blanking is entered only with the flag high.
- A blanking interval without a tick never ends.
- The counter expiry leads back to the armed state.
- The counter never passes its terminal value.

The exact lengths of the on and off windows cannot be expressed as simple properties over a 50-tick window. Neither can the restart of qualification after a short glitch, the insensitivity of blanking to flag activity, or the steady-state retry rhythm. Only the bench scenarios show these, by measuring window lengths at the ports and by comparing every cycle against a reference timing model.

// File: rtl/backcur_pkg.sv
package backcur_pkg;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_QUALIFY  = 2'd1,
        ST_BLANK    = 2'd2
    } bc_state_e;

endpackage

// File: rtl/backcur_tick_count.sv
module backcur_tick_count #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/backcur_fsm.sv
module backcur_fsm
    import backcur_pkg::*;
#(
    parameter int QUAL_MS = 2,
    parameter int OFF_MS  = 50,
    parameter int CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             rev_flag,
    input  logic [CNT_W-1:0] count,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output bc_state_e        state,
    output logic             out_en,
    output logic             bc_fault
);

    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_MS);
    localparam logic [CNT_W-1:0] OFF_LAST  = CNT_W'(OFF_MS - 1);

    bc_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ARMED;
        end else begin
            state <= nxt;
        end
    end

    // transitions and counter control
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state)
            ST_ARMED: begin
                cnt_clr = 1'b1;
                if (rev_flag) begin
                    nxt = ST_QUALIFY;              // flag seen
                end
            end
            ST_QUALIFY: begin
                if (!rev_flag) begin
                    nxt     = ST_ARMED;            // flag dropped
                    cnt_clr = 1'b1;
                end else if (ms_tick) begin
                    if (count == QUAL_LAST) begin
                        nxt     = ST_BLANK;        // fault qualified
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_BLANK: begin
                if (ms_tick) begin
                    if (count == OFF_LAST) begin
                        nxt     = ST_ARMED;        // blank expired
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: begin
                nxt     = ST_ARMED;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_BLANK: begin
                out_en   = 1'b0;
                bc_fault = 1'b1;
            end
            default: begin
                out_en   = 1'b1;
                bc_fault = 1'b0;
            end
        endcase
    end

    // R9
    blank_entry_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bc_fault) |-> $past(ms_tick));

    // R9
    blank_exit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bc_fault) |-> $past(ms_tick));

    // R3
    blank_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bc_fault) |-> $past(rev_flag));

    // R6
    blank_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK && !ms_tick) |=> (state == ST_BLANK));

    // R4
    blank_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK && ms_tick && count == OFF_LAST) |=> (state == ST_ARMED));

endmodule

// File: rtl/backcur_retry.sv
module backcur_retry
    import backcur_pkg::*;
#(
    parameter int QUAL_MS = 2,
    parameter int OFF_MS  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic rev_flag,
    output logic out_en,
    output logic bc_fault
);

    localparam int CNT_TOP = (QUAL_MS > OFF_MS - 1) ? QUAL_MS : OFF_MS - 1;
    localparam int CNT_W   = (CNT_TOP < 1) ? 1 : $clog2(CNT_TOP + 1);

    logic [CNT_W-1:0] count;
    logic             cnt_clr;
    logic             cnt_inc;
    bc_state_e        state;

    backcur_tick_count #(.WIDTH(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    backcur_fsm #(.QUAL_MS(QUAL_MS), .OFF_MS(OFF_MS), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .rev_flag (rev_flag),
        .count    (count),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .state    (state),
        .out_en   (out_en),
        .bc_fault (bc_fault)
    );

    // R3 R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(CNT_TOP));

    // R2
    armed_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUALIFY && !rev_flag) |=> (count == '0 && out_en));

endmodule

// File: tb/backcur_retry_test.sv
module backcur_retry_test;

    localparam int QUAL_MS  = 2;
    localparam int OFF_MS   = 50;
    localparam int TICK_DIV = 4;
    localparam int OFF_CYC  = OFF_MS * TICK_DIV;
    localparam int ON_CYC   = (QUAL_MS + 1) * TICK_DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic rev_flag = 1'b0;
    logic out_en;
    logic bc_fault;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tdiv = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    backcur_retry #(.QUAL_MS(QUAL_MS), .OFF_MS(OFF_MS)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .rev_flag (rev_flag),
        .out_en   (out_en),
        .bc_fault (bc_fault)
    );

    // free-running millisecond strobe, driven away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            tdiv    <= 0;
            ms_tick <= 1'b0;
        end else begin
            tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
            ms_tick <= (tdiv == TICK_DIV - 1);
        end
    end

    // reference timing model built from the requirements
    bit m_on;
    bit m_hi;
    int m_held;
    int m_left;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_on <= 1'b1; m_hi <= 1'b0; m_held <= 0; m_left <= 0;
        end else if (m_on) begin
            if (!rev_flag) begin
                m_held <= 0; m_hi <= 1'b0;
            end else if (!m_hi) begin
                m_hi <= 1'b1;
            end else if (ms_tick) begin
                if (m_held >= QUAL_MS) begin
                    m_on <= 1'b0; m_left <= OFF_MS; m_held <= 0; m_hi <= 1'b0;
                end else begin
                    m_held <= m_held + 1;
                end
            end
        end else if (ms_tick) begin
            if (m_left == 1) begin
                m_on <= 1'b1; m_hi <= 1'b0;
            end else begin
                m_left <= m_left - 1;
            end
        end
    end

    function automatic bit exp_fault(input bit on);
        return !on;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model (R3 R4 R5 R6 R7 R8)
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            check("R3/R4 out_en vs model", int'(out_en), int'(m_on));
            check("R5 bc_fault vs model", int'(bc_fault), int'(exp_fault(m_on)));
        end
    end

    task automatic finish_run;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 190000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic wait_fault;
        int g = 0;
        while (!bc_fault && g < 2000) begin
            @(negedge clk);
            g++;
        end
    endtask

    initial begin
        int off_n;
        int on_n;
        int lows;
        void'($urandom(32'd4242));

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 out_en in reset", int'(out_en), 1);
        check("R1 bc_fault in reset", int'(bc_fault), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_en after reset", int'(out_en), 1);
        check("R1 bc_fault after reset", int'(bc_fault), 0);

        // R2 short pulses with one-cycle gaps never qualify
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            rev_flag = 1'b1;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (!out_en) lows++;
            end
            rev_flag = 1'b0;
            @(negedge clk);
            if (!out_en) lows++;
        end
        check("R2 glitches keep output on", lows, 0);

        // R3 R4 R7 persistent reverse current
        repeat (20) @(negedge clk);
        rev_flag = 1'b1;
        wait_fault();
        for (int rep = 0; rep < 3; rep++) begin
            off_n = 0;
            while (bc_fault) begin
                off_n++;
                @(negedge clk);
            end
            check("R4 blanking length", off_n, OFF_CYC);
            on_n = 0;
            while (out_en && on_n < 1000) begin
                on_n++;
                @(negedge clk);
            end
            if (rep > 0 || on_n > 0) check("R7 retry on-window", on_n, ON_CYC);
        end

        // R6 flag activity during blanking, then R8 recovery
        off_n = 0;
        while (bc_fault) begin
            rev_flag = ((off_n % 7) < 3);
            off_n++;
            @(negedge clk);
        end
        check("R6 blanking unaffected by flag", off_n, OFF_CYC);
        rev_flag = 1'b0;
        lows = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (!out_en || bc_fault) lows++;
        end
        check("R8 stays enabled after removal", lows, 0);

        // random bursts compared against the model every cycle
        for (int b = 0; b < 250; b++) begin
            rev_flag = 1'b1;
            repeat ($urandom_range(1, 60)) @(negedge clk);
            rev_flag = 1'b0;
            repeat ($urandom_range(1, 250)) @(negedge clk);
        end

        // R8 final quiet check
        repeat (OFF_CYC + 10) @(negedge clk);
        check("R8 quiet output enabled", int'(out_en), 1);
        finish_run();
    end

endmodule